// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block sits between a clocked host and an asynchronous static RAM with a 19-bit address, an 8-bit data bus and three active-low strobes (chip select, output enable, write enable). The host offers one word at a time on a valid/ready handshake, with a read/write flag, an address and write data. The controller runs the strobes through a fixed, cycle-counted sequence. A read ends with a one-cycle response pulse that carries the captured byte.

Every wait in the sequence is derived at elaboration from the memory's timing limits in nanoseconds and the clock period. Each wait is the ceiling of its limit divided by the period. The defaults describe the fastest (70 ns) grade on a 100 MHz clock. Slower grades only need new nanosecond parameters. The data bus is split into an output byte, an input byte and a drive enable for the pad's tri-state buffer.

Top module: `sram_async_ctrl`

## Requirements
- R1: Strobe decode follows three modes. Idle and recovery cycles keep chip select, output enable and write enable all high (standby). Read cycles have chip select and output enable low with write enable high. Write cycles have chip select and write enable low with output enable high.
- R2: While reset is held, ready is high, the response pulse is low, all three strobes are high and the data bus is not driven.
- R3: A read keeps its strobes and address for RD_CYC = ceil(max(address access, chip-enable access, output-enable access) / period) cycles. The input byte is sampled at the clock edge ending the last of those cycles.
- R4: The response pulse is high for exactly one cycle, the cycle after a read's strobes end. It carries the byte the memory returned.
- R5: A write holds write enable low for WR_CYC = ceil(max(write pulse, address-to-write-end, select-to-write-end, data setup) / period) cycles. One more cycle follows with write enable high while chip select stays low.
- R6: The controller drives the data bus only during the write-enable-low cycles and the cycle after them. Address and write data stay constant from the first strobe cycle to the last.
- R7: After a read, all strobes stay high and the bus stays undriven for max(ceil(float time / period), ceil(cycle time / period) − RD_CYC) cycles.
- R8: Successive chip-select falling edges are at least ceil(cycle time / period) cycles apart.
- R9: Ready is low from the cycle after a request is accepted until its sequence ends. A valid pulse while ready is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write byte |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_rdata | output | DATA_W | Captured read byte |
| sram_addr | output | ADDR_W | Memory address pins |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_dq_o | output | DATA_W | Byte driven onto the data bus |
| sram_dq_oe | output | 1 | Drive enable for the data bus buffer |
| sram_dq_i | input | DATA_W | Byte read from the data bus |

## Verification
Several properties are checked on every cycle. Strobe combinations must be legal, and the bus may be driven only while output enable is high and chip select is low. The write-enable pulse and read strobe windows must be long enough, there must be enough undriven cycles after output enable rises, and chip-select falls must be spaced far enough apart. Address stability during an access, the single-cycle response and low ready during access are also checked continuously. Only the bench's scenarios can show that bytes written reach the right location and come back on a later read. The memory model returns garbage before the access time expires, so only the scenarios can also show that a byte is sampled late enough to be the stored value and not garbage, and that a valid pulse during a busy period starts no extra access.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_READ  = 3'd1,
      ST_WRITE = 3'd2,
      ST_WHOLD = 3'd3,
      ST_GAP   = 3'd4
   } seq_state_t;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // read strobe window: slowest of address, select and output-enable access
   function automatic int rd_cycles(input int clk_ns, input int t_aa, input int t_acs, input int t_oe);
      return max2(1, max2(ceil_div(t_aa, clk_ns), max2(ceil_div(t_acs, clk_ns), ceil_div(t_oe, clk_ns))));
   endfunction

   // write-enable-low window: pulse width, address/select to end, data setup
   function automatic int wr_cycles(input int clk_ns, input int t_wp, input int t_aw, input int t_cw, input int t_dw);
      return max2(1, max2(max2(ceil_div(t_wp, clk_ns), ceil_div(t_aw, clk_ns)),
                          max2(ceil_div(t_cw, clk_ns), ceil_div(t_dw, clk_ns))));
   endfunction

   // idle cycles after a read: output float time and cycle-time remainder
   function automatic int rd_gap_cycles(input int clk_ns, input int t_rc, input int t_hz, input int rd);
      return max2(ceil_div(t_hz, clk_ns), ceil_div(t_rc, clk_ns) - rd);
   endfunction

   // idle cycles after a write's hold cycle to complete the cycle time
   function automatic int wr_gap_cycles(input int clk_ns, input int t_rc, input int wr);
      return max2(0, ceil_div(t_rc, clk_ns) - wr - 1);
   endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
   import sram_ctrl_pkg::*;
#(
   parameter int RD_CYC = 7,
   parameter int WR_CYC = 7,
   parameter int RD_GAP = 3,
   parameter int WR_GAP = 0,
   parameter int CNT_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_fire,
   input  logic             req_write,
   input  logic             tmr_done,
   output seq_state_t       state,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output logic             capture
);

   seq_state_t       nxt;
   seq_state_t       rd_exit;
   seq_state_t       wr_exit;
   logic [CNT_W-1:0] rd_exit_len;
   logic [CNT_W-1:0] wr_exit_len;

   // the recovery stage exists only when its derived length is non-zero
   if (RD_GAP > 0) begin : g_rd_gap
      assign rd_exit     = ST_GAP;
      assign rd_exit_len = CNT_W'(RD_GAP - 1);
   end else begin : g_rd_direct
      assign rd_exit     = ST_IDLE;
      assign rd_exit_len = '0;
   end

   if (WR_GAP > 0) begin : g_wr_gap
      assign wr_exit     = ST_GAP;
      assign wr_exit_len = CNT_W'(WR_GAP - 1);
   end else begin : g_wr_direct
      assign wr_exit     = ST_IDLE;
      assign wr_exit_len = '0;
   end

   always_comb begin
      nxt      = state;
      tmr_load = 1'b0;
      tmr_val  = '0;
      capture  = 1'b0;
      case (state)
         ST_IDLE: begin
            if (req_fire) begin
               tmr_load = 1'b1;
               if (req_write) begin
                  nxt     = ST_WRITE;
                  tmr_val = CNT_W'(WR_CYC - 1);
               end else begin
                  nxt     = ST_READ;
                  tmr_val = CNT_W'(RD_CYC - 1);
               end
            end
         end
         ST_READ: begin
            if (tmr_done) begin
               capture  = 1'b1;
               nxt      = rd_exit;
               tmr_load = 1'b1;
               tmr_val  = rd_exit_len;
            end
         end
         ST_WRITE: begin
            if (tmr_done) nxt = ST_WHOLD;
         end
         ST_WHOLD: begin
            nxt      = wr_exit;
            tmr_load = 1'b1;
            tmr_val  = wr_exit_len;
         end
         ST_GAP: begin
            if (tmr_done) nxt = ST_IDLE;
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

endmodule

// File: rtl/sram_bus_path.sv
module sram_bus_path #(
   parameter int ADDR_W = 19,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_fire,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              capture,
   input  logic [DATA_W-1:0] dq_in,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic [DATA_W-1:0] rdata_q,
   output logic              rvalid_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (req_fire) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q  <= '0;
         rvalid_q <= 1'b0;
      end else begin
         rvalid_q <= capture;
         if (capture) rdata_q <= dq_in;
      end
   end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W   = 19,
   parameter int DATA_W   = 8,
   parameter int CLK_NS   = 10,
   parameter int T_RC_NS  = 70,
   parameter int T_AA_NS  = 70,
   parameter int T_ACS_NS = 70,
   parameter int T_OE_NS  = 35,
   parameter int T_HZ_NS  = 25,
   parameter int T_WP_NS  = 50,
   parameter int T_AW_NS  = 65,
   parameter int T_CW_NS  = 60,
   parameter int T_DW_NS  = 30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] sram_addr,
   output logic              sram_cs_n,
   output logic              sram_oe_n,
   output logic              sram_we_n,
   output logic [DATA_W-1:0] sram_dq_o,
   output logic              sram_dq_oe,
   input  logic [DATA_W-1:0] sram_dq_i
);

   localparam int RD_CYC  = rd_cycles(CLK_NS, T_AA_NS, T_ACS_NS, T_OE_NS);
   localparam int WR_CYC  = wr_cycles(CLK_NS, T_WP_NS, T_AW_NS, T_CW_NS, T_DW_NS);
   localparam int RD_GAP  = rd_gap_cycles(CLK_NS, T_RC_NS, T_HZ_NS, RD_CYC);
   localparam int WR_GAP  = wr_gap_cycles(CLK_NS, T_RC_NS, WR_CYC);
   localparam int CNT_MAX = max2(max2(RD_CYC, WR_CYC), max2(RD_GAP, WR_GAP));
   localparam int CNT_W   = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX);

   initial begin
      assert (CLK_NS > 0) else $error("clock period must be positive");
      assert (ADDR_W > 0 && DATA_W > 0) else $error("bus widths must be positive");
      assert (T_RC_NS > 0 && T_AA_NS > 0 && T_WP_NS > 0) else $error("timing limits must be positive");
   end

   seq_state_t       state;
   logic             req_fire;
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_done;
   logic             capture;
   logic [DATA_W-1:0] wdata_q;

   assign req_ready = (state == ST_IDLE);
   assign req_fire  = req_valid && req_ready;

   sram_seq_fsm #(
      .RD_CYC (RD_CYC),
      .WR_CYC (WR_CYC),
      .RD_GAP (RD_GAP),
      .WR_GAP (WR_GAP),
      .CNT_W  (CNT_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_fire  (req_fire),
      .req_write (req_write),
      .tmr_done  (tmr_done),
      .state     (state),
      .tmr_load  (tmr_load),
      .tmr_val   (tmr_val),
      .capture   (capture)
   );

   sram_wait_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .done     (tmr_done)
   );

   sram_bus_path #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_bus (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_fire  (req_fire),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .capture   (capture),
      .dq_in     (sram_dq_i),
      .addr_q    (sram_addr),
      .wdata_q   (wdata_q),
      .rdata_q   (rsp_rdata),
      .rvalid_q  (rsp_valid)
   );

   assign sram_dq_o = wdata_q;

   // strobe decode straight from the registered sequence state
   always_comb begin
      sram_cs_n  = 1'b1;
      sram_oe_n  = 1'b1;
      sram_we_n  = 1'b1;
      sram_dq_oe = 1'b0;
      case (state)
         ST_READ: begin
            sram_cs_n = 1'b0;
            sram_oe_n = 1'b0;
         end
         ST_WRITE: begin
            sram_cs_n  = 1'b0;
            sram_we_n  = 1'b0;
            sram_dq_oe = 1'b1;
         end
         ST_WHOLD: begin
            sram_cs_n  = 1'b0;
            sram_dq_oe = 1'b1;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W   = 19,
   parameter int CLK_NS   = 10,
   parameter int T_RC_NS  = 70,
   parameter int T_AA_NS  = 70,
   parameter int T_ACS_NS = 70,
   parameter int T_OE_NS  = 35,
   parameter int T_HZ_NS  = 25,
   parameter int T_WP_NS  = 50,
   parameter int T_AW_NS  = 65,
   parameter int T_CW_NS  = 60,
   parameter int T_DW_NS  = 30
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] sram_addr,
   input logic              sram_cs_n,
   input logic              sram_oe_n,
   input logic              sram_we_n,
   input logic              sram_dq_oe
);

   localparam int K_RD = rd_cycles(CLK_NS, T_AA_NS, T_ACS_NS, T_OE_NS);
   localparam int K_WR = wr_cycles(CLK_NS, T_WP_NS, T_AW_NS, T_CW_NS, T_DW_NS);
   localparam int K_HZ = ceil_div(T_HZ_NS, CLK_NS);
   localparam int K_RC = ceil_div(T_RC_NS, CLK_NS);
   localparam int SAT  = 4096;

   int oe_low_run;
   int we_low_run;
   int oe_high_run;
   int since_cs_fall;
   logic cs_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_low_run    <= 0;
         we_low_run    <= 0;
         oe_high_run   <= SAT;
         since_cs_fall <= SAT;
         cs_prev       <= 1'b1;
      end else begin
         oe_low_run  <= !sram_oe_n ? ((oe_low_run < SAT) ? oe_low_run + 1 : SAT) : 0;
         we_low_run  <= !sram_we_n ? ((we_low_run < SAT) ? we_low_run + 1 : SAT) : 0;
         oe_high_run <= sram_oe_n ? ((oe_high_run < SAT) ? oe_high_run + 1 : SAT) : 0;
         since_cs_fall <= (cs_prev && !sram_cs_n) ? 1
                        : ((since_cs_fall < SAT) ? since_cs_fall + 1 : SAT);
         cs_prev     <= sram_cs_n;
      end
   end

   assert_standby_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      sram_cs_n |-> (sram_we_n && sram_oe_n));

   assert_no_oe_in_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |-> sram_oe_n);

   // read strobes were low for the full access window before the response
   assert_read_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ($past(oe_low_run) >= K_RD - 1));

   assert_rsp_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   assert_we_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_we_n) |-> ($past(we_low_run) >= K_WR - 1));

   assert_drive_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sram_dq_oe |-> (!sram_cs_n && sram_oe_n));

   assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_cs_n && !$past(sram_cs_n)) |-> $stable(sram_addr));

   assert_turnaround_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sram_dq_oe |-> (oe_high_run >= K_HZ));

   assert_cycle_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sram_cs_n) |-> (since_cs_fall >= K_RC));

   assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_cs_n |-> !req_ready);

endmodule

bind sram_async_ctrl sram_ctrl_checker #(
   .ADDR_W   (ADDR_W),
   .CLK_NS   (CLK_NS),
   .T_RC_NS  (T_RC_NS),
   .T_AA_NS  (T_AA_NS),
   .T_ACS_NS (T_ACS_NS),
   .T_OE_NS  (T_OE_NS),
   .T_HZ_NS  (T_HZ_NS),
   .T_WP_NS  (T_WP_NS),
   .T_AW_NS  (T_AW_NS),
   .T_CW_NS  (T_CW_NS),
   .T_DW_NS  (T_DW_NS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ready  (req_ready),
   .rsp_valid  (rsp_valid),
   .sram_addr  (sram_addr),
   .sram_cs_n  (sram_cs_n),
   .sram_oe_n  (sram_oe_n),
   .sram_we_n  (sram_we_n),
   .sram_dq_oe (sram_dq_oe)
);

// File: tb/sim_sram_async_ctrl.sv
module sim_sram_async_ctrl;

   localparam int AW  = 19;
   localparam int DW  = 8;
   localparam int TCK = 20;
   // waits from the 70 ns grade limits at a 20 ns period
   localparam int B_RD   = (70 + TCK - 1) / TCK;
   localparam int B_WR   = (65 + TCK - 1) / TCK;
   localparam int B_RC   = (70 + TCK - 1) / TCK;
   localparam int B_HZ   = (25 + TCK - 1) / TCK;
   localparam int B_RGAP = (B_HZ > B_RC - B_RD) ? B_HZ : B_RC - B_RD;
   localparam int B_WGAP = (B_RC - B_WR - 1 > 0) ? B_RC - B_WR - 1 : 0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr  = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_ready;
   logic          rsp_valid;
   logic [DW-1:0] rsp_rdata;
   logic [AW-1:0] sram_addr;
   logic          sram_cs_n;
   logic          sram_oe_n;
   logic          sram_we_n;
   logic [DW-1:0] sram_dq_o;
   logic          sram_dq_oe;
   logic [DW-1:0] sram_dq_i = 8'hEE;

   sram_async_ctrl #(.CLK_NS(TCK)) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_write  (req_write),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .rsp_valid  (rsp_valid),
      .rsp_rdata  (rsp_rdata),
      .sram_addr  (sram_addr),
      .sram_cs_n  (sram_cs_n),
      .sram_oe_n  (sram_oe_n),
      .sram_we_n  (sram_we_n),
      .sram_dq_o  (sram_dq_o),
      .sram_dq_oe (sram_dq_oe),
      .sram_dq_i  (sram_dq_i)
   );

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;
   bit run   = 1'b0;

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   // ---------------- memory model: garbage until access time has elapsed
   logic [7:0] mem [int];
   int  acc     = 0;
   logic we_prev = 1'b1;

   always @(posedge clk) begin
      #2;
      if (!sram_cs_n && !sram_oe_n && sram_we_n) acc++;
      else acc = 0;
      if (!sram_cs_n && sram_we_n && !we_prev && sram_dq_oe)
         mem[int'(sram_addr)] = sram_dq_o;
      we_prev = sram_we_n;
      if (acc >= B_RD)
         sram_dq_i = mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : 8'h00;
      else
         sram_dq_i = 8'hEE;
   end

   // ---------------- behavioural reference: queue of expected cycles
   typedef struct packed {
      logic [2:0]    ph;   // 0 idle, 1 read, 2 read recovery, 3 write, 4 write hold, 5 write recovery
      logic          cs_n;
      logic          oe_n;
      logic          we_n;
      logic          doe;
      logic          rv;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
   } exp_t;

   exp_t       q[$];
   logic [7:0] rd_q[$];
   logic [7:0] shadow [int];

   function automatic exp_t mk(logic [2:0] ph, logic cs, logic oe, logic we, logic doe, logic rv,
                               logic [AW-1:0] a, logic [DW-1:0] d);
      exp_t e;
      e.ph = ph; e.cs_n = cs; e.oe_n = oe; e.we_n = we; e.doe = doe; e.rv = rv; e.a = a; e.d = d;
      return e;
   endfunction

   bit was_empty;
   always @(posedge clk) begin
      if (rst_n) begin
         was_empty = (q.size() == 0);
         if (!was_empty) void'(q.pop_front());
         if (was_empty && req_valid) begin
            if (req_write) begin
               shadow[int'(req_addr)] = req_wdata;
               for (int i = 0; i < B_WR; i++) q.push_back(mk(3'd3, 0, 1, 0, 1, 0, req_addr, req_wdata));
               q.push_back(mk(3'd4, 0, 1, 1, 1, 0, req_addr, req_wdata));
               for (int i = 0; i < B_WGAP; i++) q.push_back(mk(3'd5, 1, 1, 1, 0, 0, req_addr, req_wdata));
            end else begin
               rd_q.push_back(shadow.exists(int'(req_addr)) ? shadow[int'(req_addr)] : 8'h00);
               for (int i = 0; i < B_RD; i++) q.push_back(mk(3'd1, 0, 0, 1, 0, 0, req_addr, 8'h00));
               for (int i = 0; i < B_RGAP; i++) q.push_back(mk(3'd2, 1, 1, 1, 0, (i == 0), req_addr, 8'h00));
            end
         end
      end
   end

   // ---------------- per-cycle comparison away from the active edge
   int last_fall = -1000;
   logic cs_seen = 1'b1;
   always @(negedge clk) begin
      exp_t  e;
      string tag;
      logic  busy;
      if (run) begin
         busy = (q.size() != 0);
         e    = busy ? q[0] : mk(3'd0, 1, 1, 1, 0, 0, '0, '0);
         case (e.ph)
            3'd1:    tag = "R3";
            3'd2:    tag = "R7";
            3'd3:    tag = "R5";
            3'd4:    tag = "R5";
            3'd5:    tag = "R8";
            default: tag = "R1";
         endcase
         chk("R9", "ready", 32'(req_ready), 32'(!busy));
         chk(tag, "cs_n", 32'(sram_cs_n), 32'(e.cs_n));
         chk(tag, "oe_n", 32'(sram_oe_n), 32'(e.oe_n));
         chk(tag, "we_n", 32'(sram_we_n), 32'(e.we_n));
         chk("R6", "dq_oe", 32'(sram_dq_oe), 32'(e.doe));
         if (!e.cs_n) chk("R6", "addr", 32'(sram_addr), 32'(e.a));
         if (e.doe)   chk("R6", "dq_o", 32'(sram_dq_o), 32'(e.d));
         chk("R4", "rsp_valid", 32'(rsp_valid), 32'(e.rv));
         if (e.rv && rd_q.size() != 0) chk("R4", "rsp_rdata", 32'(rsp_rdata), 32'(rd_q.pop_front()));
         if (cs_seen && !sram_cs_n) begin
            chk("R8", "cs spacing ok", 32'(cyc - last_fall >= B_RC), 32'd1);
            last_fall = cyc;
         end
         cs_seen = sram_cs_n;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 40000) begin
         n_bad++;
         $display("FAIL watchdog: run stalled at cycle %0d", cyc);
         summary();
         $finish;
      end
   end

   // ---------------- stimulus
   task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = a;
      req_wdata = d;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // R9: a valid pulse while busy must start nothing
   task automatic junk_pulse(input logic [AW-1:0] a);
      if (!req_ready) begin
         req_valid = 1'b1;
         req_write = 1'b1;
         req_addr  = a;
         req_wdata = 8'h99;
         @(negedge clk);
         req_valid = 1'b0;
      end
   endtask

   initial begin
      logic [AW-1:0] addrs [8];
      repeat (3) @(negedge clk);
      // R2: reset state
      chk("R2", "ready", 32'(req_ready), 32'd1);
      chk("R2", "rsp_valid", 32'(rsp_valid), 32'd0);
      chk("R2", "cs_n", 32'(sram_cs_n), 32'd1);
      chk("R2", "oe_n", 32'(sram_oe_n), 32'd1);
      chk("R2", "we_n", 32'(sram_we_n), 32'd1);
      chk("R2", "dq_oe", 32'(sram_dq_oe), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      run = 1'b1;
      @(negedge clk);

      issue(1'b1, 19'h7FFFF, 8'hA5);
      junk_pulse(19'h00011);
      issue(1'b1, 19'h00000, 8'h3C);
      junk_pulse(19'h00022);
      issue(1'b0, 19'h7FFFF, 8'h00);
      junk_pulse(19'h00033);
      issue(1'b0, 19'h00000, 8'h00);
      issue(1'b0, 19'h12345, 8'h00);   // never written: memory returns zero

      for (int i = 0; i < 8; i++) begin
         addrs[i] = AW'((i * 40503 + 777) & 32'h7FFFF);
         issue(1'b1, addrs[i], 8'((i * 37) ^ 8'h5A));
      end
      for (int i = 7; i >= 0; i--) issue(1'b0, addrs[i], 8'h00);

      issue(1'b1, 19'h00055, 8'h01);
      issue(1'b1, 19'h00055, 8'hFE);
      issue(1'b0, 19'h00055, 8'h00);
      for (int i = 0; i < 4; i++) begin
         issue(1'b1, AW'(19'h40000 + i), 8'(8'hC0 + i));
         issue(1'b0, AW'(19'h40000 + i), 8'h00);
      end

      repeat (12) @(negedge clk);
      chk("R9", "idle at end", 32'(req_ready), 32'd1);
      summary();
      $finish;
   end

endmodule